// File: doc/BRIEF.md
# Software Interrupt Register Bank

This block gives software a way to raise an inter-processor interrupt on any hart of a multi-hart cluster. It presents one 32-bit register slot per hart on a simple request/response memory bus and drives one interrupt line per hart. The number of harts is a parameter.

A mode parameter picks one of two variants. In the machine variant each slot holds a pending bit. Software can set it, clear it and read it back, and the bit drives a held level on the hart's line. In the supervisor variant each slot is a write-only set port. A write of one sends a single-cycle set pulse to a pending register that sits on the hart side, outside this block. Reads of that variant always return zero, and writes of zero do nothing.

Every bus request is answered one cycle later, whether or not it decodes. Illegal or undecoded accesses have no side effect. The interrupt lines are driven straight from flip-flops.

The response path is a two-state machine, `RSP_IDLE` and `RSP_BUSY`. It moves from `RSP_IDLE` to `RSP_BUSY` on a request (transition *accept*). It stays in `RSP_BUSY` while requests keep arriving back to back (transition *chain*). It returns to `RSP_IDLE` when a cycle passes with no request (transition *drain*). It stays in `RSP_IDLE` while there is no request (transition *wait*).

Top module: `swi_bank`

## Requirements
- R1: The slot for hart i sits at byte offset 4*i. A legal write whose data bit 0 is 1 raises hart i's interrupt and leaves every other hart unchanged.
- R2: In machine mode, a legal write whose data bit 0 is 0 lowers hart i's line. Data bits 31..1 are ignored in both modes.
- R3: In machine mode, a legal read returns the hart's pending bit in bit 0 and zeros in bits 31..1.
- R4: An access at an offset of 4*N_HARTS or above is undecoded. Such a write changes no line, and such a read returns zero.
- R5: An access is legal only if its size code is 2 (size codes: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes) and address bits 1..0 are 00. An illegal write changes no line, and an illegal read returns zero.
- R6: Reset drives every interrupt line low and clears every machine-mode pending bit.
- R7: `bus_ready` is high in the cycle after each cycle that has `bus_req` high, and only then. `bus_rdata` is valid while `bus_ready` is high and is zero otherwise.
- R8: In supervisor mode, a legal write of 1 raises the hart's line for exactly one cycle, the cycle after the request.
- R9: In supervisor mode, writes of 0 leave every line low, and every read returns zero.
- R10: The lines change only in the cycle after a write request. In machine mode the new level then holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one access per cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the bank |
| bus_size | input | 2 | Access size code (2 = 4 bytes) |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Response strobe, one cycle after the request |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| irq_o | output | N_HARTS | Per-hart software interrupt line |

## Verification
The bench drives a machine-mode instance and a supervisor-mode instance from the same bus, so every stimulus is judged against both behaviours.

It targets the following corner cases:
- Writes just past the last slot. A decoder that wraps the slot index would raise hart 0.
- Sub-word and double-word accesses, and writes to offsets inside a slot. A design that skips the size or alignment check would set or clear a pending bit.
- Clearing writes that carry ones in the upper data bits. A design that tests the whole word would leave the bit set.
- Supervisor writes. A design that holds the level would be seen still high one cycle after the pulse.
- A clearing write in supervisor mode would be seen doing something.
- Back-to-back requests. They check that every request gets its own response cycle.

// File: rtl/swb_pkg.sv
package swb_pkg;

    // Variant of the bank
    typedef enum logic {
        MODE_MACHINE = 1'b0,
        MODE_SUPER   = 1'b1
    } swi_mode_e;

    // Response state machine
    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_BUSY = 1'b1
    } rsp_state_e;

    // Classification of one bus access
    typedef enum logic [1:0] {
        ACC_SLOT     = 2'd0,
        ACC_BADSHAPE = 2'd1,
        ACC_UNMAPPED = 2'd2
    } acc_kind_e;

    // Size code of a 4-byte access
    localparam logic [1:0] SIZE_WORD = 2'd2;

endpackage

// File: rtl/swb_decode.sv
module swb_decode
    import swb_pkg::*;
#(
    parameter int N_HARTS = 4,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = (N_HARTS > 1) ? $clog2(N_HARTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);

    localparam int SLOT_W = ADDR_W - 2;

    logic [SLOT_W-1:0] slot;

    assign slot = addr[ADDR_W-1:2];
    assign idx  = addr[IDX_W+1:2];

    always_comb begin
        if (slot >= SLOT_W'(N_HARTS)) begin
            kind = ACC_UNMAPPED;
        end else if ((size != SIZE_WORD) || (addr[1:0] != 2'b00)) begin
            kind = ACC_BADSHAPE;
        end else begin
            kind = ACC_SLOT;
        end
    end

endmodule

// File: rtl/swb_slot.sv
module swb_slot
    import swb_pkg::*;
#(
    parameter swi_mode_e MODE = MODE_MACHINE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic line,
    output logic pend
);

    generate
        if (MODE == MODE_MACHINE) begin : g_level
            logic level_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    level_q <= 1'b0;
                end else if (wr_en) begin
                    level_q <= wr_bit;
                end
            end

            assign line = level_q;
            assign pend = level_q;
        end else begin : g_pulse
            logic pulse_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pulse_q <= 1'b0;
                end else begin
                    pulse_q <= wr_en & wr_bit;
                end
            end

            assign line = pulse_q;
            assign pend = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/swb_resp.sv
module swb_resp
    import swb_pkg::*;
#(
    parameter int N_HARTS = 4,
    localparam int IDX_W  = (N_HARTS > 1) ? $clog2(N_HARTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  acc_kind_e          kind,
    input  logic [IDX_W-1:0]   idx,
    input  logic [N_HARTS-1:0] pend,
    output logic               ready,
    output logic [31:0]        rdata
);

    rsp_state_e state_q, state_d;
    logic       rd_bit_q;
    logic       sel_bit;

    // The index is in range whenever the access decodes as a slot
    always_comb begin
        sel_bit = 1'b0;
        for (int i = 0; i < N_HARTS; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_bit = pend[i];
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: state_d = req ? RSP_BUSY : RSP_IDLE;
            RSP_BUSY: state_d = req ? RSP_BUSY : RSP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Read data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bit_q <= 1'b0;
        end else begin
            rd_bit_q <= req && !we && (kind == ACC_SLOT) && sel_bit;
        end
    end

    // Outputs
    always_comb begin
        ready = 1'b0;
        rdata = '0;
        unique case (state_q)
            RSP_IDLE: begin
                ready = 1'b0;
                rdata = '0;
            end
            RSP_BUSY: begin
                ready = 1'b1;
                rdata = {31'd0, rd_bit_q};
            end
        endcase
    end

endmodule

// File: rtl/swi_bank.sv
module swi_bank
    import swb_pkg::*;
#(
    parameter int        N_HARTS = 4,
    parameter int        ADDR_W  = 12,
    parameter swi_mode_e MODE    = MODE_MACHINE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [1:0]         bus_size,
    input  logic [31:0]        bus_wdata,
    output logic               bus_ready,
    output logic [31:0]        bus_rdata,
    output logic [N_HARTS-1:0] irq_o
);

    localparam int IDX_W = (N_HARTS > 1) ? $clog2(N_HARTS) : 1;

    acc_kind_e          kind;
    logic [IDX_W-1:0]   idx;
    logic [N_HARTS-1:0] pend;
    logic               wr_ok;

    swb_decode #(.N_HARTS(N_HARTS), .ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .size (bus_size),
        .kind (kind),
        .idx  (idx)
    );

    assign wr_ok = bus_req && bus_we && (kind == ACC_SLOT);

    generate
        for (genvar i = 0; i < N_HARTS; i++) begin : g_slot
            swb_slot #(.MODE(MODE)) u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_ok && (idx == IDX_W'(i))),
                .wr_bit (bus_wdata[0]),
                .line   (irq_o[i]),
                .pend   (pend[i])
            );
        end
    endgenerate

    swb_resp #(.N_HARTS(N_HARTS)) u_resp (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (bus_req),
        .we    (bus_we),
        .kind  (kind),
        .idx   (idx),
        .pend  (pend),
        .ready (bus_ready),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/swb_chk.sv
module swb_chk
    import swb_pkg::*;
#(
    parameter int        N_HARTS = 4,
    parameter int        ADDR_W  = 12,
    parameter swi_mode_e MODE    = MODE_MACHINE
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_req,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [1:0]         bus_size,
    input logic [31:0]        bus_wdata,
    input logic               bus_ready,
    input logic [31:0]        bus_rdata,
    input logic [N_HARTS-1:0] irq_o
);

    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * N_HARTS);

    // R7
    ready_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ready);

    // R7
    no_stray_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_ready);

    // R3
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:1] == 31'd0);

    // R4
    unmapped_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && (bus_addr >= SPAN)) |=>
            ((MODE == MODE_MACHINE) ? $stable(irq_o) : (irq_o == '0)));

    generate
        if (MODE == MODE_MACHINE) begin : g_machine
            // R10
            lines_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(bus_req && bus_we) |=> $stable(irq_o));

            // R5
            badshape_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_req && bus_we && ((bus_size != SIZE_WORD) || (bus_addr[1:0] != 2'b00)))
                    |=> $stable(irq_o));

            // R2
            clear_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_req && bus_we && (bus_size == SIZE_WORD) && (bus_addr == '0)
                    && !bus_wdata[0]) |=> !irq_o[0]);
        end else begin : g_super
            // R8
            single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_o != '0) |=> ((irq_o & $past(irq_o)) == '0));

            // R9
            super_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                bus_rdata == 32'd0);

            // R9
            super_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_req && bus_we && !bus_wdata[0]) |=> (irq_o == '0));

            // R10
            super_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(bus_req && bus_we) |=> (irq_o == '0));
        end
    endgenerate

endmodule

bind swi_bank swb_chk #(.N_HARTS(N_HARTS), .ADDR_W(ADDR_W), .MODE(MODE)) u_swb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
);

// File: tb/test_swi_bank.sv
module test_swi_bank;
    import swb_pkg::*;

    localparam int NH = 4;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = 2'd2;
    logic [31:0]   bus_wdata = '0;
    logic          rdy_m, rdy_s;
    logic [31:0]   rd_m, rd_s;
    logic [NH-1:0] irq_m, irq_s;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [NH-1:0] exp_pend = '0;

    always #2.5 clk = ~clk;

    swi_bank #(.N_HARTS(NH), .ADDR_W(AW), .MODE(MODE_MACHINE)) i_swi_bank (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_ready(rdy_m), .bus_rdata(rd_m), .irq_o(irq_m)
    );

    swi_bank #(.N_HARTS(NH), .ADDR_W(AW), .MODE(MODE_SUPER)) i_swi_bank_sup (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_ready(rdy_s), .bus_rdata(rd_s), .irq_o(irq_s)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access; returns at the negedge after the response edge
    task automatic access(input logic we, input logic [AW-1:0] a,
                          input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 machine lines after reset", 32'(irq_m), 32'h0);
        check("R6 super lines after reset", 32'(irq_s), 32'h0);
        check("R7 no ready in reset", 32'(rdy_m), 32'h0);
        rst_n = 1'b1;
        exp_pend = '0;
    endtask

    task automatic t_raise_each();
        for (int h = 0; h < NH; h++) begin
            access(1'b1, AW'(4 * h), 2'd2, 32'h0000_0001);
            exp_pend[h] = 1'b1;
            check("R1 machine level per slot", 32'(irq_m), 32'(exp_pend));
            check("R8 super pulse on own hart", 32'(irq_s), 32'(1 << h));
            check("R7 write ready", 32'(rdy_m), 32'h1);
            @(negedge clk);
            check("R8 super pulse one cycle", 32'(irq_s), 32'h0);
            check("R10 machine level holds", 32'(irq_m), 32'(exp_pend));
            check("R7 ready drops", 32'(rdy_m), 32'h0);
        end
    endtask

    task automatic t_readback();
        for (int h = 0; h < NH; h++) begin
            access(1'b0, AW'(4 * h), 2'd2, 32'h0);
            check("R3 machine read pending", rd_m, {31'd0, exp_pend[h]});
            check("R9 super read zero", rd_s, 32'h0);
            check("R7 read ready", 32'(rdy_s), 32'h1);
        end
    endtask

    task automatic t_clear();
        access(1'b1, AW'(4), 2'd2, 32'hFFFF_FFFE);
        exp_pend[1] = 1'b0;
        check("R2 clear ignores upper bits", 32'(irq_m), 32'(exp_pend));
        check("R9 super zero write no effect", 32'(irq_s), 32'h0);
        access(1'b0, AW'(4), 2'd2, 32'h0);
        check("R3 read after clear", rd_m, 32'h0);
        access(1'b1, AW'(8), 2'd2, 32'hFFFF_FFFF);
        check("R2 set ignores upper bits", 32'(irq_m), 32'(exp_pend));
        check("R8 super pulse slot2", 32'(irq_s), 32'h4);
    endtask

    task automatic t_unmapped();
        access(1'b1, AW'(4), 2'd2, 32'h1);
        exp_pend[1] = 1'b1;
        access(1'b1, AW'(4 * NH), 2'd2, 32'h0);
        check("R4 write past end leaves lines", 32'(irq_m), 32'(exp_pend));
        access(1'b1, AW'(4 * NH), 2'd2, 32'h1);
        check("R4 super no pulse past end", 32'(irq_s), 32'h0);
        access(1'b0, AW'(4 * NH), 2'd2, 32'h0);
        check("R4 read past end zero", rd_m, 32'h0);
        check("R7 undecoded still answered", 32'(rdy_m), 32'h1);
        access(1'b1, AW'(12'h400), 2'd2, 32'h0);
        check("R4 far address no wrap", 32'(irq_m), 32'(exp_pend));
    endtask

    task automatic t_badshape();
        access(1'b1, AW'(4 + 2), 2'd2, 32'h0);
        check("R5 misaligned write ignored", 32'(irq_m), 32'(exp_pend));
        access(1'b1, AW'(4), 2'd0, 32'h0);
        check("R5 byte write ignored", 32'(irq_m), 32'(exp_pend));
        access(1'b1, AW'(4), 2'd3, 32'h0);
        check("R5 double write ignored", 32'(irq_m), 32'(exp_pend));
        access(1'b1, AW'(12), 2'd1, 32'h1);
        check("R5 super half write ignored", 32'(irq_s), 32'h0);
        access(1'b0, AW'(1), 2'd2, 32'h0);
        check("R5 misaligned read zero", rd_m, 32'h0);
        access(1'b0, AW'(0), 2'd0, 32'h0);
        check("R5 byte read zero", rd_m, 32'h0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = AW'(0); bus_size = 2'd2;
        @(negedge clk);
        check("R7 first of pair ready", 32'(rdy_m), 32'h1);
        check("R3 first of pair data", rd_m, {31'd0, exp_pend[0]});
        bus_addr = AW'(4 * 3);
        @(negedge clk);
        bus_req = 1'b0;
        check("R7 second of pair ready", 32'(rdy_m), 32'h1);
        check("R3 second of pair data", rd_m, {31'd0, exp_pend[3]});
        @(negedge clk);
        check("R7 ready ends after pair", 32'(rdy_m), 32'h0);
    endtask

    task automatic t_reset_mid();
        check("R6 pending before reset", 32'(irq_m != '0), 32'h1);
        t_reset();
        access(1'b0, AW'(0), 2'd2, 32'h0);
        check("R6 pending cleared by reset", rd_m, 32'h0);
    endtask

    initial begin
        t_reset();
        t_raise_each();
        t_readback();
        t_clear();
        t_unmapped();
        t_badshape();
        t_back_to_back();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule